// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache that sits between a processor read port and a main memory that returns one word at a time. Processor addresses are 15 bits wide and words are 12 bits wide. The low 9 address bits select one of 512 sets. The upper 6 bits are kept as a tag. Each set has two ways, and each way holds a valid flag, a tag and one data word. Two words with the same set index can therefore be resident together.

The cache is looked up in the cycle a request is accepted. On a hit, the word comes back in the next cycle. On a miss, the block raises a memory request for the same address and holds it until memory signals ready. It then writes the returned word into a victim way and passes the word to the processor in the following cycle. An empty way is filled first. When both ways are valid, a one-bit per-set recency marker picks the least recently used way. Two saturating counters, one for hits and one for misses, let software compute the hit ratio as hits/(hits+misses).

Top module: `cache2w`

## Requirements
- R1: After reset, cpu_ready is 1, rsp_valid and mem_req are 0, and both counters read 0. Every way is invalid, so the first access to any address misses.
- R2: Take a request accepted at a rising edge (cpu_req=1 while cpu_ready=1). If its tag (address bits 14:9) matches a valid way of the set at address bits 8:0, the block drives rsp_valid=1 with the stored word in the next cycle, and mem_req stays 0.
- R3: A request that misses raises mem_req in the next cycle, with mem_addr equal to the requested address. mem_req stays high until a cycle in which mem_ready=1, and cpu_ready is 0 for that whole time.
- R4: On a miss, the cycle after the edge that samples mem_ready=1 carries rsp_valid=1 with rsp_data equal to the mem_data sampled at that edge. mem_req is then low. The word is installed, so the same address hits afterwards.
- R5: Two addresses with the same index and different tags can both be resident at once, so both then hit.
- R6: When a set has an invalid way, a fill uses it and evicts no valid word.
- R7: When both ways of a set are valid, a fill replaces the way used less recently. Both hits and fills count as use.
- R8: hit_count goes up by one for each accepted hit. miss_count goes up by one for each accepted miss.
- R9: Each counter saturates at its maximum value (0xFFFF) and does not wrap.
- R10: Sets are independent. Fills and evictions in one set leave the contents of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Read request from the processor |
| cpu_addr | input | 15 | Read address |
| cpu_ready | output | 1 | High when a request can be accepted |
| rsp_valid | output | 1 | One-cycle strobe: rsp_data holds the read word |
| rsp_data | output | 12 | Read word |
| mem_req | output | 1 | Fetch request to main memory |
| mem_addr | output | 15 | Fetch address |
| mem_ready | input | 1 | Main memory has mem_data ready |
| mem_data | input | 12 | Word returned by main memory |
| hit_count | output | 16 | Saturating hit counter |
| miss_count | output | 16 | Saturating miss counter |

## Verification
The bench works through sets at both ends of the index range and in the middle. In each set it runs tag sequences that first fill the empty ways and then force evictions after mixed hits. A design that ignores invalid ways would throw away a live word while an empty slot remains. A design whose recency marker is updated only on fills would evict the word that was just read. Varying memory latencies check that a fetch request that drops early, or a response launched before memory is ready, returns the wrong word. Long runs of back-to-back hits reach the counter limit, so a counter that wraps shows up as a small value.

// File: rtl/cache2w.sv
module cache2w #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;

  logic [TAG_W-1:0]  tag0 [SETS];
  logic [TAG_W-1:0]  tag1 [SETS];
  logic [DATA_W-1:0] dat0 [SETS];
  logic [DATA_W-1:0] dat1 [SETS];
  logic [SETS-1:0]   vld0, vld1, lru;
  logic              busy;
  logic [ADDR_W-1:0] pend;

  wire [IDX_W-1:0] q_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] q_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire hit0 = vld0[q_idx] && (tag0[q_idx] == q_tag);
  wire hit1 = vld1[q_idx] && (tag1[q_idx] == q_tag);
  wire take = cpu_req && !busy;

  wire [IDX_W-1:0] p_idx = pend[IDX_W-1:0];
  wire [TAG_W-1:0] p_tag = pend[ADDR_W-1:IDX_W];
  wire victim = !vld0[p_idx] ? 1'b0 : (!vld1[p_idx] ? 1'b1 : lru[p_idx]);
  wire fill   = busy && mem_ready;

  assign cpu_ready = !busy;
  assign mem_req   = busy;
  assign mem_addr  = pend;

  always_ff @(posedge clk) begin
    if (fill) begin
      if (victim) begin
        tag1[p_idx] <= p_tag;
        dat1[p_idx] <= mem_data;
      end else begin
        tag0[p_idx] <= p_tag;
        dat0[p_idx] <= mem_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend       <= '0;
      vld0       <= '0;
      vld1       <= '0;
      lru        <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (take) begin
        if (hit0 || hit1) begin
          rsp_valid   <= 1'b1;
          rsp_data    <= hit1 ? dat1[q_idx] : dat0[q_idx];
          lru[q_idx]  <= !hit1;
          if (hit_count != '1) hit_count <= hit_count + 1'b1;
        end else begin
          busy <= 1'b1;
          pend <= cpu_addr;
          if (miss_count != '1) miss_count <= miss_count + 1'b1;
        end
      end
      if (fill) begin
        busy       <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_data   <= mem_data;
        lru[p_idx] <= !victim;
        if (victim) vld1[p_idx] <= 1'b1;
        else        vld0[p_idx] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              rsp_valid,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !cpu_ready); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R3
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_ready |=> rsp_valid && !mem_req); // R4
  AST_NO_RSP_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> !rsp_valid); // R4
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) !(cpu_req && cpu_ready) && !(mem_req && mem_ready) |=> !rsp_valid); // R2
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (hit_count - $past(hit_count)) <= 1); // R8
  AST_HIT_SAT: assert property (@(posedge clk) disable iff (!rst_n) hit_count == '1 |=> hit_count == '1); // R9
  AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n) miss_count == '1 |=> miss_count == '1); // R9
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_ready(cpu_ready),
  .rsp_valid(rsp_valid), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_ready(mem_ready), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/test_cache2w.sv
module test_cache2w;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0, cpu_req = 0, mem_ready = 0;
  logic [14:0] cpu_addr = '0;
  logic [11:0] mem_data = '0;
  logic        cpu_ready, rsp_valid, mem_req;
  logic [11:0] rsp_data;
  logic [14:0] mem_addr;
  logic [15:0] hit_count, miss_count;

  int checks = 0, errors = 0, hits = 0, misses = 0;
  bit done = 0;

  logic [5:0] m_tag [512][2];
  bit         m_vld [512][2];
  bit         m_old [512];

  always #(PERIOD/2) clk = ~clk;

  cache2w i_cache2w (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [11:0] word_of(logic [14:0] a);
    return 12'((a * 7) ^ (a >> 3) ^ 12'h5A5);
  endfunction

  function automatic bit model_hit(logic [14:0] a);
    int s = a[8:0];
    for (int w = 0; w < 2; w++)
      if (m_vld[s][w] && m_tag[s][w] == a[14:9]) return 1;
    return 0;
  endfunction

  function automatic void model_update(logic [14:0] a);
    int s = a[8:0];
    int v;
    for (int w = 0; w < 2; w++)
      if (m_vld[s][w] && m_tag[s][w] == a[14:9]) begin m_old[s] = !w; return; end
    v = !m_vld[s][0] ? 0 : (!m_vld[s][1] ? 1 : int'(m_old[s]));
    m_vld[s][v] = 1; m_tag[s][v] = a[14:9]; m_old[s] = !v;
  endfunction

  task automatic access(logic [14:0] a, int lat, string r);
    bit h = model_hit(a);
    @(negedge clk);
    chk({r, "/R1 ready before request"}, cpu_ready, 1);
    cpu_req = 1; cpu_addr = a;
    @(negedge clk);
    cpu_req = 0;
    if (h) begin
      hits++;
      chk({r, "/R2 hit strobe"}, rsp_valid, 1);
      chk({r, "/R2 hit data"}, rsp_data, word_of(a));
      chk({r, "/R2 no fetch on hit"}, mem_req, 0);
    end else begin
      misses++;
      chk({r, "/R3 fetch raised"}, mem_req, 1);
      chk({r, "/R3 fetch address"}, mem_addr, a);
      chk({r, "/R3 stalled"}, cpu_ready, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk({r, "/R3 fetch held"}, {mem_req, rsp_valid}, 2'b10);
      end
      mem_ready = 1; mem_data = word_of(a);
      @(negedge clk);
      mem_ready = 0; mem_data = 12'hBAD;
      chk({r, "/R4 fill strobe"}, rsp_valid, 1);
      chk({r, "/R4 fill data"}, rsp_data, word_of(a));
      chk({r, "/R4 fetch dropped"}, mem_req, 0);
    end
    model_update(a);
    chk({r, "/R8 hit count"}, hit_count, hits);
    chk({r, "/R8 miss count"}, miss_count, misses);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 512; s++) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0; m_old[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", cpu_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 counters", {hit_count, miss_count}, 0);

    // R1 / R6 / R5: two tags into empty set 3, then both hit
    access({6'd10, 9'd3}, 0, "R1");
    access({6'd20, 9'd3}, 2, "R6");
    access({6'd10, 9'd3}, 0, "R5");
    access({6'd20, 9'd3}, 0, "R5");
    // R7: tag 20 most recent, so tag 30 evicts tag 10
    access({6'd30, 9'd3}, 1, "R7");
    access({6'd20, 9'd3}, 0, "R7");
    access({6'd10, 9'd3}, 3, "R7");
    access({6'd30, 9'd3}, 0, "R7");
    // R10: same tags in neighbouring sets are independent
    access({6'd10, 9'd4}, 1, "R10");
    access({6'd30, 9'd3}, 0, "R10");
    access({6'd10, 9'd3}, 0, "R10");

    // sweep over edge and middle sets with mixed tag sequences
    foreach (m_old[k]) begin end
    for (int si = 0; si < 4; si++) begin
      int s = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 255 : 511;
      for (int i = 0; i < 40; i++) begin
        int t = ((i * 5 + si) % 7) % 4;
        access({6'(t * 17 + si), 9'(s)}, i % 4, "R7 sweep");
      end
    end
    access({6'd10, 9'd4}, 0, "R10 sweep");

    // R9: saturate hit counter with back-to-back hits
    @(negedge clk);
    cpu_addr = {6'd10, 9'd4}; cpu_req = 1;
    for (int i = 0; i < 65600; i++) @(negedge clk);
    chk("R2 back-to-back hit strobe", rsp_valid, 1);
    cpu_req = 0;
    @(negedge clk);
    chk("R9 hit counter saturated", hit_count, 16'hFFFF);
    chk("R9 miss counter unchanged", miss_count, misses);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule